// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block keeps an asynchronous DRAM array alive. After reset it waits out a long power-up pause. It then runs a fixed number of warm-up refresh cycles and only then raises `init_done` to let normal accesses begin. From then on an interval timer spreads one refresh per row-slot evenly over the retention period. Every refresh is a CAS-before-RAS cycle, so the DRAM's internal row counter supplies the row and no address is driven.

The scheduler shares the strobes with the host access sequencer. When it has work it raises `req`. It starts a cycle only in a clock where `gnt` is high, and it keeps `req` high until the cycle, including its precharge, has finished. Intervals that pass while the grant is withheld are counted, up to a saturating limit, and are then issued back to back. An inactivity watch restarts whenever RAS is active, whether driven by this block or reported by the host through `host_ras_act`. If RAS stays inactive for longer than the retention period, the block withdraws `init_done` and repeats the warm-up cycles without a new pause.

Control states: `RF_PAUSE` (power-up wait), `RF_WARM_REQ` (warm-up cycle wanted), `RF_WARM_CYC` (warm-up cycle running), `RF_READY` (initialized, idle), `RF_REF_CYC` (periodic refresh running).
- `RF_PAUSE` goes to `RF_WARM_REQ` when the pause ends.
- `RF_WARM_REQ` goes to `RF_WARM_CYC` on a grant.
- `RF_WARM_CYC` goes to `RF_WARM_REQ` when the cycle ends and more warm-ups remain, and to `RF_READY` after the last one.
- `RF_READY` goes to `RF_WARM_REQ` when the inactivity watch expires. Otherwise it goes to `RF_REF_CYC` on a grant while the backlog is non-zero.
- `RF_REF_CYC` goes to `RF_READY` when the cycle ends.

Cycle phases: `PH_IDLE`, `PH_CAS_LEAD` (CAS low, RAS high), `PH_STROBE` (both low), `PH_PRECHARGE` (both high).

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, `ras_n` and `cas_n` are 1, and `req` and `init_done` are 0.
- R2: No strobe goes low during the first `PAUSE_CYC` clock cycles after reset release. While `init_done` and `req` are both 0, both strobes stay high.
- R3: Exactly `WARM_CYCLES` refresh cycles (counted as RAS falling edges) happen before `init_done` first becomes 1. `init_done` rises at an idle point, with both strobes high and `req` low.
- R4: Each cycle is CAS-before-RAS. `cas_n` is low for exactly `T_CSR` cycles before `ras_n` falls, `ras_n` never falls while `cas_n` is high, and both strobes return high in the same clock.
- R5: `ras_n` stays low for exactly `T_RAS` cycles per refresh, and it is high for at least `T_RP` cycles before every fall.
- R6: Once initialized and served promptly, the block issues one refresh per `REF_INTERVAL_CYC` cycles. The interval timer starts when `init_done` rises.
- R7: `cas_n` falls only in the clock after one where both `req` and `gnt` were 1. `req` stays 1 for as long as `cas_n` is low.
- R8: Intervals that elapse without a grant are counted up to `MAX_BACKLOG`, and any beyond that are dropped. Once the grant returns, exactly `min(missed, MAX_BACKLOG)` cycles follow back to back, before the next interval ends.
- R9: If RAS is inactive for `IDLE_LIMIT_CYC` cycles after its last rise, `init_done` falls within a few cycles of that point. `WARM_CYCLES` cycles then rerun with no new pause, and the pending backlog is discarded.
- R10: A pulse on `host_ras_act` restarts the inactivity watch, so a host that keeps RAS active holds `init_done` at 1 even while refresh grants are withheld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gnt | input | 1 | Bus grant from the access sequencer, meaningful while `req` is 1 |
| host_ras_act | input | 1 | High in any clock in which the host drives RAS active |
| req | output | 1 | Bus request, held for the full refresh cycle |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| init_done | output | 1 | High when power-up or re-initialization is complete |

## Verification
The checks assume that the access sequencer raises `gnt` only while `req` is high. They also assume that it never drives the strobes itself during a granted cycle, so every strobe edge seen at the ports belongs to this block. The bench models the sequencer as `gnt = req & enable`, and it changes the enable only on falling clock edges. It pulses `host_ras_act` for one clock at a time. Grant-blocked windows are aligned to an observed refresh so that the number of elapsed intervals, and with it the expected backlog, follows exactly from the interval length. The backlog depth is swept from zero past saturation.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        RF_PAUSE,
        RF_WARM_REQ,
        RF_WARM_CYC,
        RF_READY,
        RF_REF_CYC
    } rf_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CAS_LEAD,
        PH_STROBE,
        PH_PRECHARGE
    } cbr_phase_e;

endpackage

// File: rtl/rfsh_cycle_timer.sv
// Free-running modulo counter that is held at zero while disabled and
// pulses tick in the last cycle of each LIMIT-cycle period.
module rfsh_cycle_timer #(
    parameter int unsigned LIMIT = 16,
    localparam int unsigned W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);

    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == LAST);

endmodule

// File: rtl/rfsh_backlog_counter.sv
// Saturating count of refresh intervals not yet served.
module rfsh_backlog_counter #(
    parameter int unsigned MAX_PEND = 8,
    localparam int unsigned CW = $clog2(MAX_PEND + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          pending
);

    localparam logic [CW-1:0] FULL = CW'(MAX_PEND);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && !dec) begin
            if (cnt_q != FULL) begin
                cnt_d = cnt_q + 1'b1;
            end
        end else if (dec && !inc) begin
            if (cnt_q != '0) begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count   = cnt_q;
    assign pending = (cnt_q != '0);

endmodule

// File: rtl/rfsh_cbr_engine.sv
// Generates one CAS-before-RAS strobe sequence per start pulse:
// CAS lead, joint strobe, then precharge with both strobes released.
module rfsh_cbr_engine
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned T_CSR = 1,
    parameter int unsigned T_RAS = 6,
    parameter int unsigned T_RP  = 5,
    localparam int unsigned TMAX = (T_RAS > T_RP) ? ((T_RAS > T_CSR) ? T_RAS : T_CSR)
                                                  : ((T_RP  > T_CSR) ? T_RP  : T_CSR),
    localparam int unsigned CW   = $clog2(TMAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done,
    output logic ras_n,
    output logic cas_n
);

    localparam logic [CW-1:0] LEAD_LAST   = CW'(T_CSR - 1);
    localparam logic [CW-1:0] STROBE_LAST = CW'(T_RAS - 1);
    localparam logic [CW-1:0] PRE_LAST    = CW'(T_RP - 1);

    cbr_phase_e    phase_q, phase_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    phase_d = PH_CAS_LEAD;
                    cnt_d   = LEAD_LAST;
                end
            end
            PH_CAS_LEAD: begin
                if (cnt_q == '0) begin
                    phase_d = PH_STROBE;
                    cnt_d   = STROBE_LAST;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_STROBE: begin
                if (cnt_q == '0) begin
                    phase_d = PH_PRECHARGE;
                    cnt_d   = PRE_LAST;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_PRECHARGE: begin
                if (cnt_q == '0) begin
                    phase_d = PH_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                phase_d = PH_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        cas_n = !((phase_q == PH_CAS_LEAD) || (phase_q == PH_STROBE));
        ras_n = !(phase_q == PH_STROBE);
        done  = (phase_q == PH_PRECHARGE) && (cnt_q == '0);
    end

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC        = 20000,
    parameter int unsigned WARM_CYCLES      = 8,
    parameter int unsigned REF_INTERVAL_CYC = 1600,
    parameter int unsigned IDLE_LIMIT_CYC   = 1640000,
    parameter int unsigned MAX_BACKLOG      = 8,
    parameter int unsigned T_CSR            = 1,
    parameter int unsigned T_RAS            = 6,
    parameter int unsigned T_RP             = 5,
    localparam int unsigned WW              = $clog2(WARM_CYCLES + 1),
    localparam int unsigned BW              = $clog2(MAX_BACKLOG + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnt,
    input  logic host_ras_act,
    output logic req,
    output logic ras_n,
    output logic cas_n,
    output logic init_done
);

    localparam logic [WW-1:0] WARM_LAST = WW'(WARM_CYCLES - 1);

    rf_state_e     state_q, state_d;
    logic [WW-1:0] warm_q;

    logic          pause_tick;
    logic          ref_tick;
    logic          idle_exp;
    logic          cyc_done;
    logic          eng_start;
    logic          ref_start;
    logic          backlog_nz;
    logic [BW-1:0] backlog;
    logic          strobe_ras_n;
    logic          warm_last;

    rfsh_cycle_timer #(.LIMIT(PAUSE_CYC)) u_pause_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q == RF_PAUSE),
        .tick  (pause_tick)
    );

    rfsh_cycle_timer #(.LIMIT(REF_INTERVAL_CYC)) u_interval_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done),
        .tick  (ref_tick)
    );

    rfsh_cycle_timer #(.LIMIT(IDLE_LIMIT_CYC)) u_idle_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done && strobe_ras_n && !host_ras_act),
        .tick  (idle_exp)
    );

    rfsh_backlog_counter #(.MAX_PEND(MAX_BACKLOG)) u_backlog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!init_done),
        .inc     (ref_tick),
        .dec     (ref_start),
        .count   (backlog),
        .pending (backlog_nz)
    );

    rfsh_cbr_engine #(
        .T_CSR (T_CSR),
        .T_RAS (T_RAS),
        .T_RP  (T_RP)
    ) u_engine (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .done  (cyc_done),
        .ras_n (strobe_ras_n),
        .cas_n (cas_n)
    );

    assign ras_n     = strobe_ras_n;
    assign warm_last = (warm_q == WARM_LAST);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RF_PAUSE: begin
                if (pause_tick) state_d = RF_WARM_REQ;
            end
            RF_WARM_REQ: begin
                if (gnt) state_d = RF_WARM_CYC;
            end
            RF_WARM_CYC: begin
                if (cyc_done) state_d = warm_last ? RF_READY : RF_WARM_REQ;
            end
            RF_READY: begin
                if (idle_exp)                state_d = RF_WARM_REQ;
                else if (backlog_nz && gnt)  state_d = RF_REF_CYC;
            end
            RF_REF_CYC: begin
                if (cyc_done) state_d = RF_READY;
            end
            default: state_d = RF_PAUSE;
        endcase
    end

    // State register and warm-up counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RF_PAUSE;
            warm_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RF_WARM_CYC && cyc_done) begin
                warm_q <= warm_last ? '0 : warm_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        init_done = 1'b0;
        req       = 1'b0;
        eng_start = 1'b0;
        ref_start = 1'b0;
        unique case (state_q)
            RF_PAUSE: begin
            end
            RF_WARM_REQ: begin
                req       = 1'b1;
                eng_start = gnt;
            end
            RF_WARM_CYC: begin
                req = 1'b1;
            end
            RF_READY: begin
                init_done = 1'b1;
                req       = backlog_nz;
                ref_start = backlog_nz && gnt && !idle_exp;
                eng_start = ref_start;
            end
            RF_REF_CYC: begin
                init_done = 1'b1;
                req       = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/dram_refresh_sched_checker.sv
module dram_refresh_sched_checker #(
    parameter int unsigned T_RAS       = 6,
    parameter int unsigned T_RP        = 5,
    parameter int unsigned MAX_BACKLOG = 8,
    localparam int unsigned BW         = $clog2(MAX_BACKLOG + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          gnt,
    input logic          req,
    input logic          ras_n,
    input logic          cas_n,
    input logic          init_done,
    input logic [BW-1:0] backlog
);

    logic [15:0] lo_cnt;
    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= 16'hFFFF;
        end else begin
            lo_cnt <= ras_n ? '0 : lo_cnt + 1'b1;
            hi_cnt <= !ras_n ? '0 : ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1);
        end
    end

    assert_quiet_before_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && !req) |-> (ras_n && cas_n));

    assert_ready_at_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (ras_n && cas_n && !req));

    assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    assert_joint_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> $rose(ras_n));

    assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (lo_cnt == 16'(T_RAS)));

    assert_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(hi_cnt) >= 16'(T_RP)));

    assert_start_granted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(gnt && req));

    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> req);

    assert_backlog_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        backlog <= BW'(MAX_BACKLOG));

endmodule

bind dram_refresh_sched dram_refresh_sched_checker #(
    .T_RAS       (T_RAS),
    .T_RP        (T_RP),
    .MAX_BACKLOG (MAX_BACKLOG)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt       (gnt),
    .req       (req),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .init_done (init_done),
    .backlog   (backlog)
);

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PAUSE      = 20;
    localparam int WARM       = 8;
    localparam int REF_INT    = 100;
    localparam int IDLE       = 1500;
    localparam int MAXB       = 8;
    localparam int T_CSR      = 1;
    localparam int T_RAS      = 3;
    localparam int T_RP       = 2;
    localparam int WD_LIMIT   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt_en = 1'b1;
    logic host_ras_act = 1'b0;
    logic gnt;
    logic req, ras_n, cas_n, init_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int falls = 0;
    int first_cas_cyc = -1;
    int lead, lo, hi;
    logic prev_cas, prev_ras, prev_gnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign gnt = req & gnt_en;

    dram_refresh_sched #(
        .PAUSE_CYC        (PAUSE),
        .WARM_CYCLES      (WARM),
        .REF_INTERVAL_CYC (REF_INT),
        .IDLE_LIMIT_CYC   (IDLE),
        .MAX_BACKLOG      (MAXB),
        .T_CSR            (T_CSR),
        .T_RAS            (T_RAS),
        .T_RP             (T_RP)
    ) u_dram_refresh_sched (
        .clk          (clk),
        .rst_n        (rst_n),
        .gnt          (gnt),
        .host_ras_act (host_ras_act),
        .req          (req),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .init_done    (init_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ras_fall();
        int f0;
        f0 = falls;
        while (falls == f0) @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (rst_n) cyc <= cyc + 1;
        if (cyc > WD_LIMIT) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    // Strobe shape monitor (R4, R5, R7)
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_cas = 1'b1; prev_ras = 1'b1; prev_gnt = 1'b0;
            lead = 0; lo = 0; hi = 1000;
        end else begin
            if (prev_cas && !cas_n) begin
                chk(prev_gnt, "R7 start only after grant", int'(prev_gnt), 1);
                if (first_cas_cyc < 0) first_cas_cyc = cyc;
            end
            if (!cas_n) chk(req, "R7 req held while strobing", int'(req), 1);
            if (prev_ras && !ras_n) begin
                chk(!cas_n && lead == T_CSR, "R4 cas lead before ras", lead, T_CSR);
                chk(hi >= T_RP, "R5 ras precharge", hi, T_RP);
                falls++;
            end
            if (!prev_ras && ras_n) begin
                chk(lo == T_RAS, "R5 ras low width", lo, T_RAS);
                chk(cas_n, "R4 joint release", int'(cas_n), 1);
            end
            if (!cas_n && ras_n) lead++;
            else if (cas_n) lead = 0;
            lo = !ras_n ? lo + 1 : 0;
            hi = ras_n ? ((hi < 1000) ? hi + 1 : hi) : 0;
            prev_cas = cas_n;
            prev_ras = ras_n;
            prev_gnt = gnt;
        end
    end

    initial begin
        int f0;
        int t0;
        int exp_n;

        // R1: reset state
        wait_cyc(4);
        chk(ras_n && cas_n, "R1 strobes high in reset", int'({ras_n, cas_n}), 3);
        chk(!req, "R1 req low in reset", int'(req), 0);
        chk(!init_done, "R1 init_done low in reset", int'(init_done), 0);
        rst_n = 1'b1;

        // R2 / R3: pause then warm-up
        while (!init_done) @(negedge clk);
        chk(first_cas_cyc >= PAUSE && first_cas_cyc <= PAUSE + 2,
            "R2 first strobe after pause", first_cas_cyc, PAUSE + 1);
        chk(falls == WARM, "R3 warm-up cycle count", falls, WARM);

        // R6: periodic refresh
        f0 = falls;
        wait_cyc(5 * REF_INT + REF_INT / 2);
        chk(falls - f0 == 5, "R6 periodic refresh count", falls - f0, 5);

        // R8: backlog sweep from zero past saturation
        for (int k = 0; k <= 10; k++) begin
            wait_ras_fall();
            gnt_en = 1'b0;
            wait_cyc(k * REF_INT);
            gnt_en = 1'b1;
            f0 = falls;
            wait_cyc(80);
            exp_n = (k > MAXB) ? MAXB : k;
            chk(falls - f0 == exp_n, $sformatf("R8 backlog drain k=%0d", k), falls - f0, exp_n);
        end

        // R9: inactivity re-initialization
        wait_ras_fall();
        gnt_en = 1'b0;
        while (!ras_n) @(negedge clk);
        t0 = cyc;
        while (init_done) @(negedge clk);
        chk(cyc - t0 >= IDLE - 2 && cyc - t0 <= IDLE + 3,
            "R9 init_done drop after inactivity", cyc - t0, IDLE);
        wait_cyc(10);
        chk(!init_done && ras_n && cas_n, "R9 waits for grant", int'(init_done), 0);
        gnt_en = 1'b1;
        f0 = falls;
        t0 = cyc;
        while (!init_done) @(negedge clk);
        chk(falls - f0 == WARM, "R9 warm-up rerun count", falls - f0, WARM);
        chk(cyc - t0 <= WARM * (T_CSR + T_RAS + T_RP + 2) + 2,
            "R9 no second pause", cyc - t0, WARM * (T_CSR + T_RAS + T_RP + 2));
        f0 = falls;
        wait_cyc(REF_INT / 2);
        chk(falls == f0, "R9 backlog discarded", falls - f0, 0);

        // R10: host activity keeps the array initialized
        wait_ras_fall();
        gnt_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            wait_cyc(500);
            chk(init_done, "R10 host activity holds init_done", int'(init_done), 1);
            host_ras_act = 1'b1;
            wait_cyc(1);
            host_ras_act = 1'b0;
        end
        gnt_en = 1'b1;
        f0 = falls;
        wait_cyc(80);
        chk(init_done, "R10 init_done still high", int'(init_done), 1);
        chk(falls - f0 == MAXB, "R10 saturated backlog drained", falls - f0, MAXB);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule